// File: doc/BRIEF.md
# Banked Shadow Register File

This block holds the host-visible configuration of a multi-channel receive core. A host reaches it over a simple single-cycle register bus. The bus gives access to a handful of global registers and to a 32-word per-channel window. Every channel word is stored twice. The processor copy is what the host writes and reads back. The active copy is what the core sees through a combinational lookup port. Active copies follow the processor copies only while a commit-enable bit is set, so software can clear the bit, stage edits across many words and channels, and then release all of them on one clock edge by setting the bit again.

A channel-select register chooses which channel the window addresses, and which of two banks: the primary-link bank or the secondary-link bank. Secondary channels implement only part of the window. A software-reset bit holds every configuration register at its reset value and drives the `soft_reset` pin while it is set. Read-only registers report the build's capabilities and a version word. A writable register holds the maximum inter-link delay, counted in 27 MHz ticks, and drives it out to the core.

The bus has no back-pressure. A write takes effect on the clock edge where `bus_we` is sampled high. `bus_rdata` is loaded on the edge where `bus_re` is sampled high and holds its value until the next read.

Top module: `shadow_regfile`

## Requirements
- R1: After hardware reset: control (0x000) reads 0x0000_0002, soft reset (0x004) reads 0, channel select (0x00C) reads 0, delay (0x028) reads 0, every window word reads 0, `soft_reset` is 0, and `max_delay` is 0.
- R2: While control bit 1 is 1, a window write (0x080–0x0FC, word index = address bits 6:2) updates the processor copy and the active copy on the same edge. The active copy can be seen on `core_data` right after that edge.
- R3: While control bit 1 is 0, active copies do not change. Window reads still return the processor copy, including values written but not yet committed.
- R4: A control write that sets bit 1 makes every pending processor value appear on the active copies together, on the edge after the one that stored the control write.
- R5: Channel select bits 7:0 give the channel number and bit 31 picks the secondary bank (1) or the primary bank (0). Each (bank, channel, word) has storage of its own.
- R6: In the secondary bank only window addresses 0x084–0x0C0 exist; they map to core-port word indices 1–16. Writes to the other secondary window addresses are ignored, and reads from them return 0.
- R7: With a selected channel number at or above NUM_CH, window writes are ignored and window reads return 0.
- R8: Bit 0 of 0x004 is the software reset and `soft_reset` follows it. While it is 1, the control, channel-select and delay registers and all copies are held at their reset values, and writes to them are ignored. Bit 0 itself stays writable.
- R9: Register 0x020 is read-only: bit 31 = seamless-switching support, bit 30 = error-correction engine present, bits 7:0 = NUM_CH, other bits 0.
- R10: Register 0x024 is read-only and returns the VERSION parameter.
- R11: Register 0x028 is a 32-bit read/write delay limit in 27 MHz ticks, driven on `max_delay`.
- R12: `bus_rdata` changes only on an edge with `bus_re` high. Addresses that are unmapped or not word aligned read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| soft_reset | output | 1 | High while the software-reset bit is set |
| max_delay | output | 32 | Inter-link delay limit in 27 MHz ticks |
| core_sec | input | 1 | Core lookup: 1 selects the secondary bank |
| core_ch | input | CH_W | Core lookup: channel index |
| core_word | input | 5 | Core lookup: window word index (0–31) |
| core_data | output | 32 | Active copy at the looked-up location, 0 if it does not exist |

## Verification
Two functions can fall on the same edge. A window write can arrive while commit is enabled, so the same edge has to capture the new value into both copies. The release of commit can also take pending edits from several channels and both banks at once. The bench stages edits with commit off, then sets the bit. It probes the core port on the half-cycle after the control write, where the old values must still be seen, and again one edge later, where every new value must be present together. A software-reset write racing against later register writes is provoked the same way, and those writes must leave nothing behind.

// File: rtl/srf_pkg.sv
package srf_pkg;

  localparam int unsigned DW        = 32;
  localparam int unsigned PRI_WORDS = 32;
  localparam int unsigned SEC_WORDS = 16;
  localparam int unsigned WIN_W     = $clog2(PRI_WORDS);
  localparam int unsigned SEC_W     = $clog2(SEC_WORDS);

  localparam logic [11:0] OFS_CTRL    = 12'h000;
  localparam logic [11:0] OFS_SRST    = 12'h004;
  localparam logic [11:0] OFS_CHSEL   = 12'h00C;
  localparam logic [11:0] OFS_SYSINFO = 12'h020;
  localparam logic [11:0] OFS_VER     = 12'h024;
  localparam logic [11:0] OFS_DELAY   = 12'h028;
  localparam logic [4:0]  WIN_PAGE    = 5'b00001;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_SRST, RG_CHSEL, RG_SYSINFO, RG_VER, RG_DELAY, RG_WIN
  } region_e;

  function automatic region_e region_of(input logic [11:0] a);
    region_e r;
    r = RG_NONE;
    if (a == OFS_CTRL)         r = RG_CTRL;
    else if (a == OFS_SRST)    r = RG_SRST;
    else if (a == OFS_CHSEL)   r = RG_CHSEL;
    else if (a == OFS_SYSINFO) r = RG_SYSINFO;
    else if (a == OFS_VER)     r = RG_VER;
    else if (a == OFS_DELAY)   r = RG_DELAY;
    else if (a[11:7] == WIN_PAGE && a[1:0] == 2'b00) r = RG_WIN;
    return r;
  endfunction

  // secondary bank covers window words 1..16
  function automatic logic sec_word_ok(input logic [WIN_W-1:0] w);
    return (w >= WIN_W'(1)) && (w <= WIN_W'(SEC_WORDS));
  endfunction

  function automatic logic [SEC_W-1:0] sec_slot(input logic [WIN_W-1:0] w);
    return SEC_W'(w - WIN_W'(1));
  endfunction

endpackage

// File: rtl/srf_ctrl_regs.sv
module srf_ctrl_regs
  import srf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  region_e       region,
  input  logic [DW-1:0] wdata,
  output logic          upd_en,
  output logic          sreset,
  output logic          sel_sec,
  output logic [7:0]    sel_ch,
  output logic [DW-1:0] delay_lim
);

  logic          upd_q;
  logic          srst_q;
  logic          sec_q;
  logic [7:0]    ch_q;
  logic [DW-1:0] delay_q;

  // the reset bit answers only to hardware reset and to its own writes
  always_ff @(posedge clk) begin
    if (rst)                          srst_q <= 1'b0;
    else if (we && region == RG_SRST) srst_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) begin
      upd_q   <= 1'b1;
      sec_q   <= 1'b0;
      ch_q    <= '0;
      delay_q <= '0;
    end else if (we) begin
      unique case (region)
        RG_CTRL:  upd_q <= wdata[1];
        RG_CHSEL: begin
          sec_q <= wdata[31];
          ch_q  <= wdata[7:0];
        end
        RG_DELAY: delay_q <= wdata;
        default: ;
      endcase
    end
  end

  assign upd_en    = upd_q;
  assign sreset    = srst_q;
  assign sel_sec   = sec_q;
  assign sel_ch    = ch_q;
  assign delay_lim = delay_q;

endmodule

// File: rtl/srf_win_decode.sv
module srf_win_decode
  import srf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [11:0]      addr,
  input  logic             sel_sec,
  input  logic [7:0]       sel_ch,
  output region_e          region,
  output logic             pri_hit,
  output logic             sec_hit,
  output logic [CH_W-1:0]  ch_idx,
  output logic [WIN_W-1:0] pri_word,
  output logic [SEC_W-1:0] sec_word
);

  localparam logic [8:0] NCH9 = 9'(NUM_CH);

  logic ch_ok;
  logic in_win;

  assign region   = region_of(addr);
  assign in_win   = (region == RG_WIN);
  assign ch_ok    = ({1'b0, sel_ch} < NCH9);
  assign ch_idx   = sel_ch[CH_W-1:0];
  assign pri_word = addr[WIN_W+1:2];
  assign sec_word = sec_slot(pri_word);
  assign pri_hit  = in_win && ch_ok && !sel_sec;
  assign sec_hit  = in_win && ch_ok && sel_sec && sec_word_ok(pri_word);

endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int NUM_CH = 4,
  parameter int WORDS  = 32,
  parameter int DW     = 32,
  parameter int CH_W   = 2,
  parameter int WW     = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            commit,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [WW-1:0]   wr_word,
  input  logic [DW-1:0]   wr_data,
  input  logic [CH_W-1:0] rd_ch,
  input  logic [WW-1:0]   rd_word,
  output logic [DW-1:0]   rd_data,
  input  logic [CH_W-1:0] act_ch,
  input  logic [WW-1:0]   act_word,
  output logic [DW-1:0]   act_data
);

  localparam int CELLS = NUM_CH * WORDS;

  logic [CELLS*DW-1:0] shd_flat;
  logic [CELLS*DW-1:0] act_flat;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DW-1:0] shd_q;
      logic [DW-1:0] act_q;
      logic [DW-1:0] shd_d;
      logic          hit;

      assign hit   = wr_en && (wr_ch == CH_W'(c)) && (wr_word == WW'(w));
      assign shd_d = hit ? wr_data : shd_q;

      // the active copy takes the post-write processor value, so a
      // commit edge and a concurrent write land together
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          shd_q <= '0;
          act_q <= '0;
        end else begin
          shd_q <= shd_d;
          if (commit) act_q <= shd_d;
        end
      end

      assign shd_flat[(c*WORDS + w)*DW +: DW] = shd_q;
      assign act_flat[(c*WORDS + w)*DW +: DW] = act_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_ch) < NUM_CH)
      rd_data = shd_flat[(int'(rd_ch)*WORDS + int'(rd_word))*DW +: DW];
  end

  always_comb begin
    act_data = '0;
    if (int'(act_ch) < NUM_CH)
      act_data = act_flat[(int'(act_ch)*WORDS + int'(act_word))*DW +: DW];
  end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter logic [31:0] VERSION  = 32'h0004_0000,
  parameter bit          SEAMLESS = 1'b1,
  parameter bit          HAS_FEC  = 1'b1,
  localparam int         CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [31:0]      bus_rdata,
  output logic             soft_reset,
  output logic [31:0]      max_delay,
  input  logic             core_sec,
  input  logic [CH_W-1:0]  core_ch,
  input  logic [4:0]       core_word,
  output logic [31:0]      core_data
);

  localparam logic [DW-1:0] SYSINFO = {SEAMLESS, HAS_FEC, 22'd0, 8'(NUM_CH)};

  logic             upd_en;
  logic             sreset;
  logic             sel_sec;
  logic [7:0]       sel_ch;
  logic [DW-1:0]    delay_lim;

  region_e          region;
  logic             pri_hit;
  logic             sec_hit;
  logic [CH_W-1:0]  ch_idx;
  logic [WIN_W-1:0] pri_word;
  logic [SEC_W-1:0] sec_word;

  logic [DW-1:0]    pri_rd;
  logic [DW-1:0]    sec_rd;
  logic [DW-1:0]    pri_act;
  logic [DW-1:0]    sec_act;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;

  srf_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .region    (region),
    .wdata     (bus_wdata),
    .upd_en    (upd_en),
    .sreset    (sreset),
    .sel_sec   (sel_sec),
    .sel_ch    (sel_ch),
    .delay_lim (delay_lim)
  );

  srf_win_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .addr     (bus_addr),
    .sel_sec  (sel_sec),
    .sel_ch   (sel_ch),
    .region   (region),
    .pri_hit  (pri_hit),
    .sec_hit  (sec_hit),
    .ch_idx   (ch_idx),
    .pri_word (pri_word),
    .sec_word (sec_word)
  );

  srf_bank #(
    .NUM_CH(NUM_CH), .WORDS(PRI_WORDS), .DW(DW), .CH_W(CH_W), .WW(WIN_W)
  ) u_pri (
    .clk      (clk),
    .rst      (rst),
    .clear    (sreset),
    .commit   (upd_en),
    .wr_en    (bus_we && pri_hit),
    .wr_ch    (ch_idx),
    .wr_word  (pri_word),
    .wr_data  (bus_wdata),
    .rd_ch    (ch_idx),
    .rd_word  (pri_word),
    .rd_data  (pri_rd),
    .act_ch   (core_ch),
    .act_word (core_word),
    .act_data (pri_act)
  );

  srf_bank #(
    .NUM_CH(NUM_CH), .WORDS(SEC_WORDS), .DW(DW), .CH_W(CH_W), .WW(SEC_W)
  ) u_sec (
    .clk      (clk),
    .rst      (rst),
    .clear    (sreset),
    .commit   (upd_en),
    .wr_en    (bus_we && sec_hit),
    .wr_ch    (ch_idx),
    .wr_word  (sec_word),
    .wr_data  (bus_wdata),
    .rd_ch    (ch_idx),
    .rd_word  (sec_word),
    .rd_data  (sec_rd),
    .act_ch   (core_ch),
    .act_word (sec_slot(core_word)),
    .act_data (sec_act)
  );

  always_comb begin
    core_data = pri_act;
    if (core_sec) core_data = sec_word_ok(core_word) ? sec_act : '0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_CTRL:    rd_mux = {30'd0, upd_en, 1'b0};
      RG_SRST:    rd_mux = {31'd0, sreset};
      RG_CHSEL:   rd_mux = {sel_sec, 23'd0, sel_ch};
      RG_SYSINFO: rd_mux = SYSINFO;
      RG_VER:     rd_mux = VERSION;
      RG_DELAY:   rd_mux = delay_lim;
      RG_WIN:     rd_mux = pri_hit ? pri_rd : (sec_hit ? sec_rd : '0);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata  = rdata_q;
  assign soft_reset = sreset;
  assign max_delay  = delay_lim;

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [11:0]     addr,
  input logic            re,
  input logic [31:0]     rdata,
  input logic            soft_reset,
  input logic [31:0]     max_delay,
  input logic            upd_en,
  input logic            sel_sec,
  input logic [7:0]      sel_ch,
  input logic            core_sec,
  input logic [CH_W-1:0] core_ch,
  input logic [4:0]      core_word,
  input logic [31:0]     core_data
);

  localparam logic [8:0] NCH9 = 9'(NUM_CH);

  logic win_addr;
  assign win_addr = (addr[11:7] == 5'b00001) && (addr[1:0] == 2'b00);

  assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!upd_en && !soft_reset) && $stable(core_sec) && $stable(core_ch)
     && $stable(core_word)) |-> $stable(core_data));

  assert_srst_delay_R8: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> (max_delay == 32'd0));

  assert_srst_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> upd_en);

  assert_sec_hole_R6: assert property (@(posedge clk) disable iff (rst)
    (re && win_addr && sel_sec && (addr[6:2] == 5'd0 || addr[6:2] > 5'd16))
    |=> (rdata == 32'd0));

  assert_bad_chan_R7: assert property (@(posedge clk) disable iff (rst)
    (re && win_addr && ({1'b0, sel_ch} >= NCH9)) |=> (rdata == 32'd0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

  assert_sysinfo_R9: assert property (@(posedge clk) disable iff (rst)
    (re && addr == 12'h020) |=> (rdata[29:8] == 22'd0 && rdata[7:0] == 8'(NUM_CH)));

endmodule

bind shadow_regfile srf_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .addr       (bus_addr),
  .re         (bus_re),
  .rdata      (bus_rdata),
  .soft_reset (soft_reset),
  .max_delay  (max_delay),
  .upd_en     (upd_en),
  .sel_sec    (sel_sec),
  .sel_ch     (sel_ch),
  .core_sec   (core_sec),
  .core_ch    (core_ch),
  .core_word  (core_word),
  .core_data  (core_data)
);

// File: tb/shadow_regfile_tb_top.sv
`timescale 1ns/100ps
module shadow_regfile_tb_top;

  localparam int          NCH = 4;
  localparam logic [31:0] VER = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        soft_reset;
  logic [31:0] max_delay;
  logic        core_sec = 1'b0;
  logic [1:0]  core_ch = '0;
  logic [4:0]  core_word = '0;
  logic [31:0] core_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  shadow_regfile #(.NUM_CH(NCH), .VERSION(VER), .SEAMLESS(1'b1), .HAS_FEC(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .soft_reset(soft_reset), .max_delay(max_delay),
    .core_sec(core_sec), .core_ch(core_ch), .core_word(core_word),
    .core_data(core_data)
  );

  function automatic logic [31:0] pat(input int s, input int c, input int w);
    return {4'hA, 3'b000, 1'(s), 8'(c), 8'(w), 8'(w) ^ 8'h5A};
  endfunction

  function automatic logic [11:0] win(input int w);
    return 12'h080 + 12'(w * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input int s, input int c, input int w, output logic [31:0] d);
    core_sec = 1'(s); core_ch = 2'(c); core_word = 5'(w);
    #0.2;
    d = core_data;
  endtask

  task automatic sel(input int s, input int c);
    wr(12'h00C, {1'(s), 23'd0, 8'(c)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 soft_reset pin", {31'd0, soft_reset}, 32'd0);
    check("R1 max_delay pin", max_delay, 32'd0);
    rd(12'h000, d); check("R1 control", d, 32'h2);
    rd(12'h004, d); check("R1 reset reg", d, 32'h0);
    rd(12'h00C, d); check("R1 chsel", d, 32'h0);
    rd(12'h028, d); check("R1 delay", d, 32'h0);
    rd(win(7), d);  check("R1 window word", d, 32'h0);
    look(0, 2, 9, d); check("R1 core active", d, 32'h0);

    // R9, R10 read-only registers, writes ignored
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h024, 32'h0);
    rd(12'h020, d); check("R9 sysinfo", d, 32'h8000_0004);
    rd(12'h024, d); check("R10 version", d, VER);

    // R12 unmapped and misaligned reads, hold without re
    rd(12'h008, d); check("R12 unmapped 0x008", d, 32'h0);
    rd(12'h02C, d); check("R12 unmapped 0x02C", d, 32'h0);
    rd(12'h100, d); check("R12 unmapped 0x100", d, 32'h0);
    rd(12'h082, d); check("R12 misaligned window", d, 32'h0);
    rd(12'h024, d);
    @(negedge clk); bus_addr = 12'h000;
    repeat (3) @(negedge clk);
    check("R12 rdata hold", bus_rdata, VER);

    // R2, R5 primary bank: write all, active follows immediately
    for (int c = 0; c < NCH; c++) begin
      sel(0, c);
      for (int w = 0; w < 32; w++) begin
        wr(win(w), pat(0, c, w));
        look(0, c, w, d); check("R2 active after write", d, pat(0, c, w));
      end
    end
    for (int c = 0; c < NCH; c++) begin
      sel(0, c);
      for (int w = 0; w < 32; w++) begin
        rd(win(w), d); check("R5 primary readback", d, pat(0, c, w));
      end
    end

    // R6 secondary bank: only words 1..16 exist
    for (int c = 0; c < NCH; c++) begin
      sel(1, c);
      for (int w = 0; w < 32; w++) wr(win(w), pat(1, c, w));
    end
    for (int c = 0; c < NCH; c++) begin
      sel(1, c);
      for (int w = 0; w < 32; w++) begin
        rd(win(w), d);
        check("R6 secondary readback", d, (w >= 1 && w <= 16) ? pat(1, c, w) : 32'h0);
        look(1, c, w, d);
        check("R6 secondary active", d, (w >= 1 && w <= 16) ? pat(1, c, w) : 32'h0);
      end
    end
    rd(12'h00C, d); check("R5 chsel readback", d, 32'h8000_0003);
    sel(0, 2);
    for (int w = 0; w < 32; w++) begin
      rd(win(w), d); check("R5 primary untouched by secondary", d, pat(0, 2, w));
    end

    // R7 out-of-range channel
    sel(0, 4);
    wr(win(0), 32'hDEAD_BEEF);
    rd(win(0), d); check("R7 read ch4", d, 32'h0);
    sel(1, 8'hFF);
    wr(win(3), 32'hDEAD_BEEF);
    rd(win(3), d); check("R7 read ch255 sec", d, 32'h0);
    sel(0, 0);
    rd(win(0), d); check("R7 ch0 not aliased", d, pat(0, 0, 0));
    sel(1, 3);
    rd(win(3), d); check("R7 sec ch3 not aliased", d, pat(1, 3, 3));

    // R3 commit disabled: stage edits
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R3 control cleared", d, 32'h0);
    sel(0, 1);
    for (int w = 0; w < 4; w++) wr(win(w), ~pat(0, 1, w));
    sel(1, 2);
    wr(win(5), ~pat(1, 2, 5));
    rd(win(5), d); check("R3 staged readback", d, ~pat(1, 2, 5));
    for (int w = 0; w < 4; w++) begin
      look(0, 1, w, d); check("R3 active frozen", d, pat(0, 1, w));
    end
    look(1, 2, 5, d); check("R3 sec active frozen", d, pat(1, 2, 5));

    // R4 release: nothing before the following edge, everything after it
    wr(12'h000, 32'h2);
    for (int w = 0; w < 4; w++) begin
      look(0, 1, w, d); check("R4 not yet committed", d, pat(0, 1, w));
    end
    look(1, 2, 5, d); check("R4 sec not yet committed", d, pat(1, 2, 5));
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      look(0, 1, w, d); check("R4 committed together", d, ~pat(0, 1, w));
    end
    look(1, 2, 5, d); check("R4 sec committed together", d, ~pat(1, 2, 5));

    // R11 delay limit
    wr(12'h028, 32'h0001_2345);
    rd(12'h028, d); check("R11 delay readback", d, 32'h0001_2345);
    check("R11 max_delay pin", max_delay, 32'h0001_2345);

    // R8 software reset
    wr(12'h004, 32'h1);
    check("R8 soft_reset high", {31'd0, soft_reset}, 32'd1);
    @(negedge clk);
    check("R8 max_delay held", max_delay, 32'h0);
    look(0, 1, 0, d); check("R8 active cleared", d, 32'h0);
    rd(12'h000, d); check("R8 control at reset", d, 32'h2);
    rd(12'h00C, d); check("R8 chsel at reset", d, 32'h0);
    rd(12'h004, d); check("R8 reset bit reads 1", d, 32'h1);
    wr(12'h028, 32'h77);
    rd(12'h028, d); check("R8 delay write ignored", d, 32'h0);
    wr(win(3), 32'h55);
    rd(win(3), d); check("R8 window write ignored", d, 32'h0);
    wr(12'h004, 32'h0);
    check("R8 soft_reset released", {31'd0, soft_reset}, 32'd0);
    wr(12'h028, 32'h99);
    rd(12'h028, d); check("R8 delay writable after release", d, 32'h99);
    rd(win(3), d); check("R8 window still clear", d, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule